// File: doc/BRIEF.md
# Byte-Burst I2C Master for Display Identification Reads

This block is an I2C master meant for fetching a monitor's identification bytes over a display data channel. It can also push short configuration writes to any slave on the same two wires. Software drives it through a small byte-wide register window. It loads a target byte whose bit 0 selects the direction, loads a length field, and fills a 16-entry byte buffer when writing. A single control write then launches the burst. The block generates START, sends the target byte, and moves length+1 bytes between the buffer and the slave. It then reports the outcome in a status register whose bits stay set until cleared.

After a burst the master keeps ownership of the bus by holding SCL low. A second control write either releases the bus with STOP or opens a new burst with a repeated START. Both lines are open-drain: each output pin is an active-high pull-low enable, and SDA is read back through a sampled input. Register access is a plain single-cycle strobe with a combinational read path. No data stream crosses the edge, so there is no valid/ready handshake and no back-pressure.

Top module: `i2c_burst_master`

## Requirements
- R1: Register offsets are fixed. Length is at 0x00 and keeps only bits 3:0; reads of it return those bits zero-extended. Control is at 0x01 and reads as 0. Status (read) and error-clear (write) share 0x02. The target byte is at 0x03. The buffer spans 0x04..0x13 as entries 0..15. Every register reads back its stored value.
- R2: A control write with bit 0 and bit 2 both set, made while no bus sequence is running, produces START. It then sends the target byte MSB first, followed by length+1 data bytes. This gives 1 byte for length 0 and 16 bytes for length 15.
- R3: When bit 0 of the target byte is 0, the data bytes are taken from buffer entries 0, 1, 2 and so on in order, and each is sent MSB first.
- R4: When bit 0 of the target byte is 1, received bytes are written to buffer entries 0, 1, 2 and so on in order. The master answers ACK (SDA low) after every byte except the last, and NACK (SDA released) after the last.
- R5: A NACK on the target byte or on any written data byte sets status bit 2 and ends the burst at once. No further byte is clocked, and SCL is left held low.
- R6: A burst that ends without error leaves status at exactly 0x08 (bit 3 set, bit 2 clear). Launching a new burst clears bit 3.
- R7: A control write with bit 0 set and bit 2 clear, made while the bus is held, produces STOP: SDA rises while SCL is high, and both lines are then released. The same write clears status bit 2 whether or not the bus is held.
- R8: A write to 0x02 with bit 2 equal to 0 clears status bit 2. A write to 0x02 with bit 2 equal to 1 leaves status unchanged.
- R9: A control write with bit 0 clear causes no bus activity and leaves status unchanged.
- R10: While a START, burst or STOP is in progress, writes to length, target byte, buffer and control are ignored.
- R11: During data and acknowledge bits, SDA changes only while SCL is low. One bit lasts four quarter periods, and a quarter period is SYS_CLK_HZ/(4*SCL_HZ) clock cycles.
- R12: After reset the length, status, target byte and all 16 buffer entries read 0, and both line enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per byte |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr (combinational) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled level of the SDA wire |

## Verification
The bench sets SYS_CLK_HZ to 125 MHz and SCL_HZ to 7.8125 MHz, so a quarter bit lasts 4 cycles and a byte with its acknowledge lasts 144 cycles. At that rate a full 16-byte read, a one-byte write, NACKs on the target byte and on a mid-burst byte, a repeated START from the held bus and the SCL period can all be reached in a few thousand cycles. BUF_DEPTH stays at 16, so the length field saturates at 15 and the buffer window ends at offset 0x13.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_COUNT = 5'h00;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h01;
  localparam logic [REG_AW-1:0] OFS_STAT  = 5'h02;
  localparam logic [REG_AW-1:0] OFS_SADDR = 5'h03;
  localparam logic [REG_AW-1:0] OFS_BUF   = 5'h04;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_GO_BIT  = 2;
  localparam int STAT_ERR_BIT = 2;
  localparam int STAT_CMP_BIT = 3;
  localparam int CLR_KEEP_BIT = 2;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_HELD,
    EN_START,
    EN_XFER,
    EN_STOP
  } eng_state_e;
endpackage

// File: rtl/i2cb_qtick.sv
module i2cb_qtick #(
  parameter int QTR = 312
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic [7:0]       target_byte,
  input  logic [IDX_W-1:0] last_idx,
  input  logic [7:0]       fetch_byte,
  output logic [IDX_W-1:0] fetch_idx,
  output logic             rx_we,
  output logic [IDX_W-1:0] rx_idx,
  output logic [7:0]       rx_data,
  output logic             done_ok,
  output logic             done_err,
  output logic             busy,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  eng_state_e       st;
  logic [1:0]       q;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic [IDX_W-1:0] idx;
  logic             addr_ph;
  logic             rd_dir;
  logic             nack_seen;

  logic tx_ph;
  logic last_byte;
  logic ack_bit;

  assign tx_ph     = addr_ph || !rd_dir;
  assign last_byte = !addr_ph && (idx == last_idx);
  assign ack_bit   = (bitn == 4'd8);
  assign fetch_idx = addr_ph ? '0 : idx + 1'b1;
  assign busy      = (st == EN_START) || (st == EN_XFER) || (st == EN_STOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= EN_IDLE;
      q         <= '0;
      bitn      <= '0;
      sh        <= '0;
      idx       <= '0;
      addr_ph   <= 1'b0;
      rd_dir    <= 1'b0;
      nack_seen <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      rx_we     <= 1'b0;
      rx_idx    <= '0;
      rx_data   <= '0;
      done_ok   <= 1'b0;
      done_err  <= 1'b0;
    end else begin
      rx_we    <= 1'b0;
      done_ok  <= 1'b0;
      done_err <= 1'b0;
      unique case (st)
        EN_IDLE: begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
          if (cmd_start) begin
            st <= EN_START;
            q  <= '0;
          end
        end
        EN_HELD: begin
          scl_oe <= 1'b1;
          if (cmd_start) begin
            st <= EN_START;
            q  <= '0;
          end else if (cmd_stop) begin
            st <= EN_STOP;
            q  <= '0;
          end
        end
        EN_START: if (tick) begin
          q <= q + 1'b1;
          unique case (q)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin
              scl_oe  <= 1'b1;
              st      <= EN_XFER;
              sh      <= target_byte;
              rd_dir  <= target_byte[0];
              addr_ph <= 1'b1;
              bitn    <= '0;
              idx     <= '0;
            end
          endcase
        end
        EN_XFER: if (tick) begin
          q <= q + 1'b1;
          unique case (q)
            2'd0: begin
              scl_oe <= 1'b1;
              if (!ack_bit) sda_oe <= tx_ph ? ~sh[7] : 1'b0;
              else          sda_oe <= tx_ph ? 1'b0 : !last_byte;
            end
            2'd1: scl_oe <= 1'b0;
            2'd2: begin
              if (!ack_bit) sh <= {sh[6:0], sda_in};
              else          nack_seen <= sda_in;
            end
            default: begin
              scl_oe <= 1'b1;
              if (!ack_bit) begin
                bitn <= bitn + 1'b1;
              end else begin
                bitn <= '0;
                if (tx_ph && nack_seen) begin
                  st       <= EN_HELD;
                  sda_oe   <= 1'b0;
                  done_err <= 1'b1;
                end else begin
                  if (!tx_ph) begin
                    rx_we   <= 1'b1;
                    rx_idx  <= idx;
                    rx_data <= sh;
                  end
                  if (last_byte) begin
                    st      <= EN_HELD;
                    sda_oe  <= 1'b0;
                    done_ok <= 1'b1;
                  end else begin
                    sh      <= fetch_byte;
                    addr_ph <= 1'b0;
                    if (!addr_ph) idx <= idx + 1'b1;
                  end
                end
              end
            end
          endcase
        end
        EN_STOP: if (tick) begin
          q <= q + 1'b1;
          unique case (q)
            2'd0: begin scl_oe <= 1'b1; sda_oe <= 1'b1; end
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: st <= EN_IDLE;
          endcase
        end
        default: st <= EN_IDLE;
      endcase
    end
  end

  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_XFER && $past(st) == EN_XFER && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R11
  AST_IDX_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_XFER && !addr_ph) |-> (idx <= last_idx)); // R2
  AST_HELD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_HELD) |-> scl_oe); // R5
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_IDLE && $past(st) == EN_IDLE) |-> (!scl_oe && !sda_oe)); // R12
endmodule

// File: rtl/i2cb_regs.sv
module i2cb_regs
  import i2cb_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              busy,
  input  logic              done_ok,
  input  logic              done_err,
  input  logic              rx_we,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic [7:0]        rx_data,
  input  logic [IDX_W-1:0]  fetch_idx,
  output logic [7:0]        fetch_byte,
  output logic [7:0]        target_byte,
  output logic [IDX_W-1:0]  last_idx,
  output logic              cmd_start,
  output logic              cmd_stop
);
  localparam int BUF_LO = int'(OFS_BUF);
  localparam int BUF_HI = BUF_LO + BUF_DEPTH;

  logic [IDX_W-1:0] cnt_q;
  logic [7:0]       addr_q;
  logic             stat_cmp;
  logic             stat_err;
  logic [7:0]       dbuf [BUF_DEPTH];

  logic             buf_hit;
  logic [IDX_W-1:0] buf_idx;
  logic             wr_open;
  logic             ctrl_take;
  logic             clr_hit;

  assign buf_hit   = (int'(bus_addr) >= BUF_LO) && (int'(bus_addr) < BUF_HI);
  assign buf_idx   = IDX_W'(bus_addr - OFS_BUF);
  assign wr_open   = bus_wr && !busy;
  assign ctrl_take = wr_open && (bus_addr == OFS_CTRL) && bus_wdata[CTRL_EN_BIT];
  assign cmd_start = ctrl_take && bus_wdata[CTRL_GO_BIT];
  assign cmd_stop  = ctrl_take && !bus_wdata[CTRL_GO_BIT];
  assign clr_hit   = bus_wr && (bus_addr == OFS_STAT) && !bus_wdata[CLR_KEEP_BIT];

  assign target_byte = addr_q;
  assign last_idx    = cnt_q;
  assign fetch_byte  = dbuf[fetch_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (wr_open) begin
      if (bus_addr == OFS_COUNT) cnt_q  <= bus_wdata[IDX_W-1:0];
      if (bus_addr == OFS_SADDR) addr_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_DEPTH; i++) dbuf[i] <= '0;
    end else if (rx_we) begin
      dbuf[rx_idx] <= rx_data;
    end else if (wr_open && buf_hit) begin
      dbuf[buf_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_cmp <= 1'b0;
      stat_err <= 1'b0;
    end else begin
      if (cmd_start) stat_cmp <= 1'b0;
      if (cmd_stop || clr_hit) stat_err <= 1'b0;
      if (done_ok) begin
        stat_cmp <= 1'b1;
        stat_err <= 1'b0;
      end
      if (done_err) stat_err <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (buf_hit) begin
      bus_rdata = dbuf[buf_idx];
    end else begin
      unique case (bus_addr)
        OFS_COUNT: bus_rdata = 8'(cnt_q);
        OFS_STAT: begin
          bus_rdata[STAT_CMP_BIT] = stat_cmp;
          bus_rdata[STAT_ERR_BIT] = stat_err;
        end
        OFS_SADDR: bus_rdata = addr_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  AST_OK_SETS_ONLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> (stat_cmp && !stat_err)); // R6
  AST_NACK_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |=> stat_err); // R5
  AST_TARGET_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && busy && bus_addr == OFS_SADDR) |=> $stable(addr_q)); // R10
  AST_LEN_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && busy && bus_addr == OFS_COUNT) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/i2c_burst_master.sv
module i2c_burst_master
  import i2cb_pkg::*;
#(
  parameter int SYS_CLK_HZ = 125_000_000,
  parameter int SCL_HZ     = 100_000,
  parameter int BUF_DEPTH  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [4:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int QTR   = SYS_CLK_HZ / (4 * SCL_HZ);
  localparam int IDX_W = $clog2(BUF_DEPTH);

  logic             tick;
  logic             busy;
  logic             cmd_start;
  logic             cmd_stop;
  logic [7:0]       target_byte;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] fetch_idx;
  logic [7:0]       fetch_byte;
  logic             rx_we;
  logic [IDX_W-1:0] rx_idx;
  logic [7:0]       rx_data;
  logic             done_ok;
  logic             done_err;

  i2cb_qtick #(.QTR(QTR)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  i2cb_regs #(.BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .done_ok    (done_ok),
    .done_err   (done_err),
    .rx_we      (rx_we),
    .rx_idx     (rx_idx),
    .rx_data    (rx_data),
    .fetch_idx  (fetch_idx),
    .fetch_byte (fetch_byte),
    .target_byte(target_byte),
    .last_idx   (last_idx),
    .cmd_start  (cmd_start),
    .cmd_stop   (cmd_stop)
  );

  i2cb_engine #(.IDX_W(IDX_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cmd_start  (cmd_start),
    .cmd_stop   (cmd_stop),
    .target_byte(target_byte),
    .last_idx   (last_idx),
    .fetch_byte (fetch_byte),
    .fetch_idx  (fetch_idx),
    .rx_we      (rx_we),
    .rx_idx     (rx_idx),
    .rx_data    (rx_data),
    .done_ok    (done_ok),
    .done_err   (done_err),
    .busy       (busy),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .sda_in     (sda_in)
  );
endmodule

// File: tb/i2c_burst_master_tb.sv
`timescale 1ns/1ps
module i2c_burst_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       scl_oe, sda_oe, sda_in;

  always #4 clk = ~clk;

  i2c_burst_master #(.SYS_CLK_HZ(125_000_000), .SCL_HZ(7_812_500), .BUF_DEPTH(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  // ---------------- slave model (open-drain wires) ----------------
  localparam logic [6:0] SLV_ADR = 7'h50;
  localparam int S_IDLE = 0, S_ADDR = 1, S_WR = 2, S_RD = 3;
  logic       s_oe = 1'b0;
  logic       scl_line, sda_line;
  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | s_oe);
  assign sda_in   = sda_line;

  logic [7:0] smem [16];
  int   s_nack_at = -1;
  logic [7:0] exp_q [$];

  int   s_st = S_IDLE;
  int   bc = 0, widx = 0, ridx = 0;
  bit   fresh = 0, s_nk = 0, s_rd = 0, mack = 0;
  logic [7:0] sh = '0, rbyte = '0;
  logic scl_p = 1'b1, sda_p = 1'b1;
  int   starts = 0, stops = 0, wbytes = 0, macks = 0, mnacks = 0;
  int   cyc = 0, last_rise = 0, per_last = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      s_st = S_IDLE; s_oe = 1'b0; scl_p = 1'b1; sda_p = 1'b1;
    end else begin
      if (scl_line && scl_p && sda_p && !sda_line) begin
        s_st = S_ADDR; bc = 0; sh = '0; s_oe = 1'b0; fresh = 1; starts++;
      end else if (scl_line && scl_p && !sda_p && sda_line) begin
        s_st = S_IDLE; s_oe = 1'b0; stops++;
      end else if (scl_line && !scl_p) begin
        per_last = cyc - last_rise; last_rise = cyc;
        if (bc < 8 && (s_st == S_ADDR || s_st == S_WR)) sh = {sh[6:0], sda_line};
        if (bc == 8 && s_st == S_RD) begin
          mack = !sda_line;
          if (mack) macks++; else mnacks++;
        end
      end else if (!scl_line && scl_p && s_st != S_IDLE) begin
        if (fresh) fresh = 0;
        else if (bc < 8) begin
          bc++;
          if (bc == 8) begin
            if (s_st == S_ADDR) begin
              s_rd = sh[0]; s_nk = (sh[7:1] != SLV_ADR); s_oe = !s_nk;
            end else if (s_st == S_WR) begin
              wbytes++;
              if (exp_q.size() == 0) check("R3 unexpected written byte", {24'd0, sh}, 32'hFFFF_FFFF);
              else check("R3 written byte", {24'd0, sh}, {24'd0, exp_q.pop_front()});
              s_nk = (s_nack_at == widx); s_oe = !s_nk; widx++;
            end else s_oe = 1'b0;
          end else if (s_st == S_RD) s_oe = ~rbyte[7-bc];
        end else begin
          bc = 0; s_oe = 1'b0;
          if (s_st == S_ADDR) begin
            if (s_nk) s_st = S_IDLE;
            else if (s_rd) begin s_st = S_RD; ridx = 0; rbyte = smem[0]; s_oe = ~rbyte[7]; end
            else begin s_st = S_WR; widx = 0; end
          end else if (s_st == S_WR) begin
            if (s_nk) s_st = S_IDLE;
          end else if (s_st == S_RD) begin
            if (mack) begin ridx++; rbyte = smem[ridx[3:0]]; s_oe = ~rbyte[7]; end
            else s_st = S_IDLE;
          end
        end
      end
      scl_p = scl_line; sda_p = sda_line;
    end
  end

  // ---------------- driver tasks ----------------
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_wr = 1'b0; bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_done(input string req);
    logic [7:0] s;
    bit seen = 0;
    for (int i = 0; i < 6000; i++) begin
      rd(5'h02, s);
      if ((s & 8'h0C) != 0) begin seen = 1; break; end
    end
    if (!seen) check({req, " burst never finished"}, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int w0, s0, a0, n0;
    for (int i = 0; i < 16; i++) smem[i] = 8'(i * 29 + 7);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(5'h00, v); check("R12 length after reset", v, 0);
    rd(5'h02, v); check("R12 status after reset", v, 0);
    rd(5'h03, v); check("R12 target after reset", v, 0);
    for (int i = 0; i < 16; i++) begin rd(5'(4 + i), v); check("R12 buffer after reset", v, 0); end
    check("R12 line enables after reset", {scl_oe, sda_oe}, 0);

    // R1 register map
    wr(5'h00, 8'hFF); rd(5'h00, v); check("R1 length keeps low 4 bits", v, 8'h0F);
    wr(5'h03, 8'h5A); rd(5'h03, v); check("R1 target readback", v, 8'h5A);
    wr(5'h13, 8'hC3); rd(5'h13, v); check("R1 last buffer entry", v, 8'hC3);
    rd(5'h01, v); check("R1 control reads zero", v, 0);

    // R2/R3 three-byte write, R10 writes ignored while busy
    wr(5'h03, 8'hA0); wr(5'h00, 8'h02);
    wr(5'h04, 8'h11); wr(5'h05, 8'h22); wr(5'h06, 8'h33);
    exp_q.push_back(8'h11); exp_q.push_back(8'h22); exp_q.push_back(8'h33);
    w0 = wbytes;
    wr(5'h01, 8'h05);
    wr(5'h04, 8'hEE); wr(5'h00, 8'h00); wr(5'h03, 8'h77);
    wait_done("R2");
    rd(5'h02, v); check("R6 status after good write", v, 8'h08);
    check("R2 bytes seen by slave", wbytes - w0, 3);
    check("R11 SCL period in cycles", per_last, 16);
    rd(5'h04, v); check("R10 buffer write ignored while busy", v, 8'h11);
    rd(5'h00, v); check("R10 length write ignored while busy", v, 8'h02);
    rd(5'h03, v); check("R10 target write ignored while busy", v, 8'hA0);
    repeat (20) @(negedge clk);
    check("R5 SCL held low after burst", scl_oe, 1);
    s0 = stops;
    wr(5'h01, 8'h01); repeat (40) @(negedge clk);
    check("R7 STOP seen on wires", stops - s0, 1);
    check("R7 lines released", {scl_oe, sda_oe}, 0);

    // R2 one-byte write (length 0)
    wr(5'h00, 8'h00); wr(5'h04, 8'h9C); exp_q.push_back(8'h9C);
    w0 = wbytes; wr(5'h01, 8'h05); wait_done("R2");
    check("R2 length 0 moves one byte", wbytes - w0, 1);
    wr(5'h01, 8'h01); repeat (40) @(negedge clk);

    // R4 four-byte read
    wr(5'h03, 8'hA1); wr(5'h00, 8'h03);
    a0 = macks; n0 = mnacks;
    wr(5'h01, 8'h05); wait_done("R4");
    rd(5'h02, v); check("R6 status after good read", v, 8'h08);
    for (int i = 0; i < 4; i++) begin rd(5'(4 + i), v); check("R4 read byte stored", v, smem[i]); end
    rd(5'h08, v); check("R4 entry past length untouched", v, 8'h00);
    check("R4 master ACK count", macks - a0, 3);
    check("R4 master NACK on last", mnacks - n0, 1);
    wr(5'h01, 8'h01); repeat (40) @(negedge clk);

    // R4 full 16-byte read
    wr(5'h00, 8'h0F); wr(5'h01, 8'h05); wait_done("R4");
    for (int i = 0; i < 16; i++) begin rd(5'(4 + i), v); check("R4 16-byte read stored", v, smem[i]); end
    wr(5'h01, 8'h01); repeat (40) @(negedge clk);

    // R5 address NACK, R8 error clear
    wr(5'h03, 8'h84); wr(5'h00, 8'h01);
    w0 = wbytes; wr(5'h01, 8'h05); wait_done("R5");
    rd(5'h02, v); check("R5 address NACK status", v, 8'h04);
    repeat (30) @(negedge clk);
    check("R5 no data byte after address NACK", wbytes - w0, 0);
    check("R5 SCL held after NACK", scl_oe, 1);
    wr(5'h02, 8'h04); rd(5'h02, v); check("R8 clear with bit 2 set ignored", v, 8'h04);
    wr(5'h02, 8'h00); rd(5'h02, v); check("R8 clear with bit 2 zero", v, 8'h00);

    // R5 NACK on second data byte, via repeated START
    wr(5'h03, 8'hA0); wr(5'h00, 8'h03);
    wr(5'h04, 8'h41); wr(5'h05, 8'h42); wr(5'h06, 8'h43); wr(5'h07, 8'h44);
    exp_q.push_back(8'h41); exp_q.push_back(8'h42);
    s_nack_at = 1; w0 = wbytes; s0 = starts;
    wr(5'h01, 8'h05); wait_done("R5");
    repeat (60) @(negedge clk);
    rd(5'h02, v); check("R5 data NACK status", v, 8'h04);
    check("R5 burst stops at NACKed byte", wbytes - w0, 2);
    check("R2 repeated START issued", starts - s0, 1);
    s_nack_at = -1; s0 = stops;
    wr(5'h01, 8'h01); repeat (40) @(negedge clk);
    rd(5'h02, v); check("R7 STOP clears error", v, 8'h00);
    check("R7 STOP after error", stops - s0, 1);

    // R9 control without enable
    s0 = starts;
    wr(5'h01, 8'h04); repeat (60) @(negedge clk);
    check("R9 no START without enable", starts - s0, 0);
    check("R9 lines stay released", {scl_oe, sda_oe}, 0);
    rd(5'h02, v); check("R9 status unchanged", v, 8'h00);

    check("R3 all expected bytes delivered", exp_q.size(), 0);
    report();
    $finish;
  end
endmodule